// File: doc/BRIEF.md
# Majority-Clocked Keystream Generator

This block produces the per-burst keystream for a GSM-style stream cipher. It holds three shift registers with linear feedback, 19, 22 and 23 bits long. A pulse on `start` latches a 64-bit session key and a 22-bit frame number, then runs a fixed setup sequence. The registers are cleared. The key bits and then the frame-number bits are mixed into the feedback of all three registers, which all step on every one of those cycles. A warm-up follows, in which each register steps only when its control bit agrees with the majority of the three control bits. Keystream bits are then produced one per cycle with a valid flag. The first 114 bits belong to the outgoing direction and the last 114 to the incoming direction. The caller XORs them with the burst data outside this block.

The sequencer is a state machine with seven states:
- `PH_IDLE`: waits for `start`, and on `start` latches the inputs and moves to `PH_ZERO`.
- `PH_ZERO`: clears the registers for one cycle, then moves to `PH_KEY`.
- `PH_KEY`: lasts 64 cycles, then moves to `PH_FRAME`.
- `PH_FRAME`: lasts 22 cycles, then moves to `PH_WARM`.
- `PH_WARM`: lasts 100 cycles, then moves to `PH_OUT`.
- `PH_OUT`: lasts 228 cycles, then moves to `PH_FIN`.
- `PH_FIN`: lasts one cycle, raises `done` and returns to `PH_IDLE`.

Only `PH_IDLE` takes a start. The output flags are registered, so each trails the step that produced it by one edge.

Top module: `mc_keystream_gen`

## Requirements
- R1: After synchronous reset, `ks_valid`, `ks_bit`, `ks_dir` and `done` are 0, and the block waits idle.
- R2: An accepted start clears all three registers to zero. Then, for 64 cycles, every register steps. Its new bit 0 is the XOR of its tap bits and key bit i (i = 0..63, least significant bit first), and its top bit is dropped.
- R3: For the next 22 cycles every register steps in the same way, with frame-number bits 0..21 (least significant bit first) XORed into the feedback.
- R4: The register lengths are 19, 22 and 23 bits. The taps are bits {13,16,17,18}, {20,21} and {7,20,21,22}, respectively.
- R5: Under majority clocking, the control bits are bit 8, bit 10 and bit 10 of registers 1, 2 and 3. A register steps only when its control bit equals the majority of the three; otherwise it holds.
- R6: 100 majority-clocked warm-up cycles follow the frame mixing. No valid bit is produced during them.
- R7: Then come 228 majority-clocked cycles. Each produces one valid bit equal to the XOR of the three most significant bits after that cycle's step. The first `ks_valid` is visible 188 clock edges after the edge that samples the start, and the valid bits are consecutive.
- R8: `ks_dir` is 0 alongside bits 0..113 (outgoing) and 1 alongside bits 114..227 (incoming).
- R9: `done` is high for exactly one cycle, the cycle right after the last valid bit, and the block is idle in that cycle. A start given in that cycle begins a new run.
- R10: A start received while a run is in progress, including the cycle that shows the last valid bit, is ignored.
- R11: Key and frame number are sampled only at the accepted start. Later changes on those inputs do not alter the running keystream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a burst setup when idle |
| session_key | input | 64 | Session key, bit 0 used first |
| frame_num | input | 22 | Frame number, bit 0 used first |
| ks_bit | output | 1 | Keystream bit |
| ks_valid | output | 1 | High while `ks_bit` carries one of the 228 bits |
| ks_dir | output | 1 | 0 = outgoing half, 1 = incoming half |
| done | output | 1 | One-cycle pulse after the last bit |

## Verification
Two things can meet in the same cycle: the end-of-run `done` pulse and a new `start`. `done` coincides with the return to idle, so a start in that cycle must be taken. A start one cycle earlier, while the last bit is shown, must be dropped. The bench tests the first case by raising a start with a fresh key exactly in the `done` cycle. It then checks that the second run has the full 188-edge latency and a bit-exact stream from the new key. It tests the second case by raising a start in the final valid cycle. It then checks that no further valid bit or `done` appears afterwards.

// File: rtl/kg_pkg.sv
package kg_pkg;
    localparam int NUM_REGS = 3;
    localparam int MAX_LEN  = 32;

    // register lengths, feedback taps (as bit masks) and majority control bits
    localparam int          KG_LEN  [NUM_REGS] = '{19, 22, 23};
    localparam logic [31:0] KG_TAPS [NUM_REGS] = '{32'h0007_2000, 32'h0030_0000, 32'h0070_0080};
    localparam int          KG_CTRL [NUM_REGS] = '{8, 10, 10};

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ZERO,
        PH_KEY,
        PH_FRAME,
        PH_WARM,
        PH_OUT,
        PH_FIN
    } kg_phase_e;
endpackage

// File: rtl/kg_lfsr_stage.sv
module kg_lfsr_stage #(
    parameter int             LEN      = 19,
    parameter logic [LEN-1:0] TAPS     = '0,
    parameter int             CTRL_BIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    input  logic inj,
    output logic ctrl_bit,
    output logic msb_nx
);
    logic [LEN-1:0] state_q;
    logic           fb;

    assign fb       = (^(state_q & TAPS)) ^ inj;
    assign ctrl_bit = state_q[CTRL_BIT];
    // top bit as it will be once this cycle's step is taken
    assign msb_nx   = step ? state_q[LEN-2] : state_q[LEN-1];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state_q <= '0;
        end else if (step) begin
            state_q <= {state_q[LEN-2:0], fb};
        end
    end

    // R2: a clear leaves an all-zero register
    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (rst)
        clr |=> (state_q == '0));

    // R5: a register that is not stepped keeps its contents
    assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (!clr && !step) |=> $stable(state_q));
endmodule

// File: rtl/kg_majority.sv
module kg_majority #(
    parameter int N = 3
) (
    input  logic [N-1:0] ctrl,
    input  logic         run_en,
    input  logic         maj_en,
    output logic [N-1:0] step
);
    logic maj;

    assign maj = (ctrl[0] & ctrl[1]) | (ctrl[0] & ctrl[2]) | (ctrl[1] & ctrl[2]);

    generate
        for (genvar g = 0; g < N; g++) begin : g_step
            assign step[g] = run_en & (~maj_en | (ctrl[g] == maj));
        end
    endgenerate
endmodule

// File: rtl/kg_seq_ctrl.sv
module kg_seq_ctrl
    import kg_pkg::*;
#(
    parameter int KEY_BITS = 64,
    parameter int FN_BITS  = 22,
    parameter int WARM_CYC = 100,
    parameter int OUT_BITS = 228
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [KEY_BITS-1:0] key_in,
    input  logic [FN_BITS-1:0]  fn_in,
    output logic                clr,
    output logic                run_en,
    output logic                maj_en,
    output logic                inj,
    output logic                out_step,
    output logic                dir,
    output logic                fin
);
    localparam int MAX_CNT = (OUT_BITS > KEY_BITS) ? ((OUT_BITS > WARM_CYC) ? OUT_BITS : WARM_CYC)
                                                   : ((KEY_BITS > WARM_CYC) ? KEY_BITS : WARM_CYC);
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam int HALF    = OUT_BITS / 2;
    localparam logic [CNT_W-1:0] KEY_LAST  = CNT_W'(KEY_BITS - 1);
    localparam logic [CNT_W-1:0] FN_LAST   = CNT_W'(FN_BITS - 1);
    localparam logic [CNT_W-1:0] WARM_LAST = CNT_W'(WARM_CYC - 1);
    localparam logic [CNT_W-1:0] OUT_LAST  = CNT_W'(OUT_BITS - 1);
    localparam logic [CNT_W-1:0] HALF_CNT  = CNT_W'(HALF);

    kg_phase_e             state_q, state_d;
    logic [CNT_W-1:0]      cnt_q, cnt_d;
    logic [KEY_BITS-1:0]   key_q, key_d;
    logic [FN_BITS-1:0]    fn_q, fn_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            key_q   <= '0;
            fn_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            key_q   <= key_d;
            fn_q    <= fn_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        key_d    = key_q;
        fn_d     = fn_q;
        clr      = 1'b0;
        run_en   = 1'b0;
        maj_en   = 1'b0;
        inj      = 1'b0;
        out_step = 1'b0;
        dir      = 1'b0;
        fin      = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                if (start) begin
                    key_d   = key_in;
                    fn_d    = fn_in;
                    state_d = PH_ZERO;
                end
            end
            PH_ZERO: begin
                clr     = 1'b1;
                cnt_d   = '0;
                state_d = PH_KEY;
            end
            PH_KEY: begin
                run_en = 1'b1;
                inj    = key_q[0];
                key_d  = key_q >> 1;
                if (cnt_q == KEY_LAST) begin
                    cnt_d   = '0;
                    state_d = PH_FRAME;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            PH_FRAME: begin
                run_en = 1'b1;
                inj    = fn_q[0];
                fn_d   = fn_q >> 1;
                if (cnt_q == FN_LAST) begin
                    cnt_d   = '0;
                    state_d = PH_WARM;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            PH_WARM: begin
                run_en = 1'b1;
                maj_en = 1'b1;
                if (cnt_q == WARM_LAST) begin
                    cnt_d   = '0;
                    state_d = PH_OUT;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            PH_OUT: begin
                run_en   = 1'b1;
                maj_en   = 1'b1;
                out_step = 1'b1;
                dir      = (cnt_q >= HALF_CNT);
                if (cnt_q == OUT_LAST) begin
                    cnt_d   = '0;
                    state_d = PH_FIN;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            PH_FIN: begin
                fin     = 1'b1;
                state_d = PH_IDLE;
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // R10: a busy sequencer never re-enters the clearing phase
    assert_busy_ignores_start_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q != PH_IDLE) |=> (state_q != PH_ZERO));

    // R6: warm-up always hands over to the output phase
    assert_warm_to_out_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_WARM && cnt_q == WARM_LAST) |=> (state_q == PH_OUT));
endmodule

// File: rtl/mc_keystream_gen.sv
module mc_keystream_gen
    import kg_pkg::*;
#(
    parameter int KEY_BITS = 64,
    parameter int FN_BITS  = 22,
    parameter int WARM_CYC = 100,
    parameter int OUT_BITS = 228
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [KEY_BITS-1:0] session_key,
    input  logic [FN_BITS-1:0]  frame_num,
    output logic                ks_bit,
    output logic                ks_valid,
    output logic                ks_dir,
    output logic                done
);
    logic                clr, run_en, maj_en, inj, out_step, dir, fin;
    logic [NUM_REGS-1:0] ctrl_v, step_v, msb_nx_v;

    kg_seq_ctrl #(
        .KEY_BITS (KEY_BITS),
        .FN_BITS  (FN_BITS),
        .WARM_CYC (WARM_CYC),
        .OUT_BITS (OUT_BITS)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .key_in   (session_key),
        .fn_in    (frame_num),
        .clr      (clr),
        .run_en   (run_en),
        .maj_en   (maj_en),
        .inj      (inj),
        .out_step (out_step),
        .dir      (dir),
        .fin      (fin)
    );

    kg_majority #(.N(NUM_REGS)) u_maj (
        .ctrl   (ctrl_v),
        .run_en (run_en),
        .maj_en (maj_en),
        .step   (step_v)
    );

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            localparam int L = KG_LEN[g];
            kg_lfsr_stage #(
                .LEN      (L),
                .TAPS     (KG_TAPS[g][L-1:0]),
                .CTRL_BIT (KG_CTRL[g])
            ) u_stage (
                .clk      (clk),
                .rst      (rst),
                .clr      (clr),
                .step     (step_v[g]),
                .inj      (inj),
                .ctrl_bit (ctrl_v[g]),
                .msb_nx   (msb_nx_v[g])
            );
        end
    endgenerate

    // output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ks_bit   <= 1'b0;
            ks_valid <= 1'b0;
            ks_dir   <= 1'b0;
            done     <= 1'b0;
        end else begin
            ks_valid <= out_step;
            ks_dir   <= out_step & dir;
            ks_bit   <= out_step & (^msb_nx_v);
            done     <= fin;
        end
    end

    // R5: under majority clocking at least two registers step
    assert_majority_two_step_R5: assert property (@(posedge clk) disable iff (rst)
        (run_en && maj_en) |-> ($countones(step_v) >= 2));

    // R9: the end of the valid window is marked by done
    assert_done_after_last_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(ks_valid) |-> done);

    // R9: done lasts one cycle
    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: within a run the direction flag never falls back to outgoing
    assert_dir_monotonic_R8: assert property (@(posedge clk) disable iff (rst)
        (ks_valid && ks_dir) |=> (!ks_valid || ks_dir));

    // R1 / R7: no valid bit alongside done
    assert_no_valid_with_done_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !ks_valid);
endmodule

// File: tb/mc_keystream_gen_tb_top.sv
module mc_keystream_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [63:0] session_key;
    logic [21:0] frame_num;
    logic        ks_bit, ks_valid, ks_dir, done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mc_keystream_gen dut_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .session_key (session_key),
        .frame_num   (frame_num),
        .ks_bit      (ks_bit),
        .ks_valid    (ks_valid),
        .ks_dir      (ks_dir),
        .done        (done)
    );

    localparam logic [18:0] MASK1 = 19'h72000;
    localparam logic [21:0] MASK2 = 22'h300000;
    localparam logic [22:0] MASK3 = 23'h700080;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // independent reference built from R2..R5, R7
    function automatic logic [227:0] ref_stream(input logic [63:0] k, input logic [21:0] f);
        logic [18:0] a = '0;
        logic [21:0] b = '0;
        logic [22:0] c = '0;
        logic [227:0] s = '0;
        for (int i = 0; i < 86; i++) begin
            logic x;
            x = (i < 64) ? k[i] : f[i-64];
            a = {a[17:0], (^(a & MASK1)) ^ x};
            b = {b[20:0], (^(b & MASK2)) ^ x};
            c = {c[21:0], (^(c & MASK3)) ^ x};
        end
        for (int i = 0; i < 328; i++) begin
            logic m;
            m = (a[8] & b[10]) | (a[8] & c[10]) | (b[10] & c[10]);
            if (a[8] == m)  a = {a[17:0], ^(a & MASK1)};
            if (b[10] == m) b = {b[20:0], ^(b & MASK2)};
            if (c[10] == m) c = {c[21:0], ^(c & MASK3)};
            if (i >= 100) s[i-100] = a[18] ^ b[21] ^ c[22];
        end
        return s;
    endfunction

    task automatic pulse_start(input logic [63:0] k, input logic [21:0] f);
        session_key = k;
        frame_num   = f;
        start       = 1'b1;
        @(negedge clk);
        start       = 1'b0;
    endtask

    // collects one run whose start edge has just passed; returns at the done cycle
    // poke=1: start pulse and input changes mid-run (R10, R11), start during last valid (R10)
    task automatic collect_run(input logic [63:0] k, input logic [21:0] f, input bit poke);
        logic [227:0] exp_s;
        int n = 0, idx = 0, first = -1, bad_bits = 0, bad_dir = 0;
        exp_s = ref_stream(k, f);
        while (1) begin
            @(negedge clk);
            n++;
            if (poke && n == 40) begin
                start = 1'b1; session_key = ~k; frame_num = ~f;
            end
            if (poke && n == 41) start = 1'b0;
            if (poke && n == 415) start = 1'b1;
            if (ks_valid) begin
                if (first < 0) first = n;
                if (idx < 228) begin
                    if (ks_bit !== exp_s[idx]) bad_bits++;
                    if (ks_dir !== (idx >= 114)) bad_dir++;
                end
                idx++;
            end
            if (done || n > 1000) break;
        end
        start = 1'b0;
        check(first == 188, "R6", "first valid edge", first, 188);
        check(idx == 228, "R7", "valid bit count", idx, 228);
        check(bad_bits == 0, "R7", "mismatching keystream bits (R2 R3 R4 R5 R11)", bad_bits, 0);
        check(bad_dir == 0, "R8", "direction flag errors", bad_dir, 0);
        check(done === 1'b1 && n == 416, "R9", "done edge", n, 416);
    endtask

    task automatic t_reset;
        rst = 1'b1; start = 1'b0; session_key = '0; frame_num = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ks_valid === 1'b0, "R1", "ks_valid after reset", ks_valid, 0);
        check(done === 1'b0, "R1", "done after reset", done, 0);
        check(ks_bit === 1'b0 && ks_dir === 1'b0, "R1", "ks_bit/ks_dir after reset", {ks_bit, ks_dir}, 0);
    endtask

    task automatic t_run(input logic [63:0] k, input logic [21:0] f);
        pulse_start(k, f);
        collect_run(k, f, 1'b0);
        @(negedge clk);
        check(done === 1'b0, "R9", "done width", done, 0);
    endtask

    task automatic t_busy_start;
        pulse_start(64'h1234_5678_9ABC_DEF0, 22'h2AB3C);
        collect_run(64'h1234_5678_9ABC_DEF0, 22'h2AB3C, 1'b1);
        begin
            int seen = 0;
            repeat (200) begin
                @(negedge clk);
                if (ks_valid || done) seen++;
            end
            check(seen == 0, "R10", "activity after ignored late start", seen, 0);
        end
    endtask

    task automatic t_back_to_back;
        pulse_start(64'h0F1E_2D3C_4B5A_6978, 22'h01234);
        collect_run(64'h0F1E_2D3C_4B5A_6978, 22'h01234, 1'b0);
        // start in the done cycle must be accepted (R9)
        pulse_start(64'hFEDC_BA98_7654_3210, 22'h3FFFF);
        collect_run(64'hFEDC_BA98_7654_3210, 22'h3FFFF, 1'b0);
        @(negedge clk);
    endtask

    initial begin
        #20ms;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_run(64'h0, 22'h0);
        t_run(64'hFFFF_FFFF_FFFF_FFFF, 22'h3FFFFF);
        t_run(64'h0000_0000_0000_0001, 22'h000000);
        t_run(64'h0000_0000_0000_0000, 22'h200000);
        t_run(64'hA5C3_1F77_0B9E_4D28, 22'h134AB);
        t_busy_start();
        t_back_to_back();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule